// File: doc/BRIEF.md
# Marshal Address Buffer for Segment Hand-off

This block sits beside one core and remembers which cache blocks that core's tagged producer stores wrote during the current code segment. Each committed store arrives with its physical address and a tag bit. A set tag bit marks the store as one whose data the next segment will consume. The block aligns the address to a 64-byte block. It records the block once, however many tagged stores hit it, and keeps up to sixteen such blocks in the order they were first written.

When the segment ends, a marshal command names the core that will run the next segment. The block then drains every recorded block address toward that core as a valid/ready push-request stream, oldest first. Each request carries the named core as its destination, so the destination cache can pull the lines in before the next segment needs them. While the drain runs, the block reports busy and records nothing. After the last request is taken it empties itself, pulses a done strobe for one cycle and starts recording the next generation. Since marshaling only helps performance, tagged stores that find the buffer full are dropped, and a sticky flag records that loss.

Top module: `marshal_addr_buf`

## Requirements
- R1: After reset, push_valid, st_busy, drain_done and overflow are all low and the buffer holds no entries.
- R2: A store with st_gen low is never recorded and never causes a push request.
- R3: Each push_addr equals the recorded store address with its low 6 bits forced to zero (64-byte blocks).
- R4: A tagged store whose block is already recorded adds no entry, so each block is pushed once per drain.
- R5: A drain issues the recorded blocks in the order they were first recorded, and every request carries as push_dest the core ID given with the marshal command that started it.
- R6: One entry leaves per cycle in which push_valid and push_ready are both high; while push_ready is low, push_valid, push_addr and push_dest hold their values.
- R7: The buffer holds 16 distinct blocks. A tagged store of a new block into a full buffer is dropped and sets overflow, which stays high until that drain completes and then clears.
- R8: From the cycle after a marshal command until the drain completes, st_busy is high. Tagged stores and further marshal commands presented in that window are ignored.
- R9: drain_done is high for exactly one cycle, the cycle right after the last push is accepted. The buffer is then empty and recording resumes.
- R10: A marshal command on an empty buffer issues no push request and raises drain_done two cycles after the command cycle.
- R11: A tagged store presented in the same cycle as the marshal command is recorded and included in that drain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | A store commits this cycle |
| st_addr | input | 48 | Physical byte address of the committing store |
| st_gen | input | 1 | Store is tagged as a producer of hand-off data |
| st_busy | output | 1 | Drain in progress; stores are not recorded |
| mc_valid | input | 1 | Marshal command this cycle |
| mc_dest | input | 5 | Core ID that runs the next segment |
| push_valid | output | 1 | Push request available |
| push_ready | input | 1 | Push request taken this cycle |
| push_addr | output | 48 | Block-aligned address to push |
| push_dest | output | 5 | Destination core of the push |
| drain_done | output | 1 | One-cycle pulse when a drain has finished |
| overflow | output | 1 | Sticky: a tagged block was dropped this generation |

## Verification
The assertions watch the handshake and framing on every cycle. They check that requests appear only while busy, that a stalled request holds its address and destination, that the destination stays fixed for the whole drain, and that the done pulse lasts one cycle, follows a busy cycle and is the only moment overflow may clear. Only the bench scenarios can show what is pushed: which stores were recorded, alignment, duplicate merging, insertion order, the drop at the sixteen-entry limit, and that stores and commands made during a drain leave no trace in the next generation.

// File: rtl/mab_pkg.sv
package mab_pkg;

  typedef enum logic [0:0] {
    MAB_RECORD = 1'b0,
    MAB_DRAIN  = 1'b1
  } mab_state_e;

endpackage

// File: rtl/mab_entry_array.sv
// Block-address storage: one write port, one read port, match against
// every occupied entry. Occupancy is the prefix [0, cnt).
module mab_entry_array #(
  parameter int DEPTH = 16,
  parameter int BLK_W = 42,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic [CNT_W-1:0] cnt,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [BLK_W-1:0] rd_blk,
  output logic             hit
);

  logic [BLK_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0] hit_vec;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        mem_q[i] <= wr_blk;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign hit_vec[g] = (CNT_W'(g) < cnt) && (mem_q[g] == wr_blk);
  end

  assign hit    = |hit_vec;
  assign rd_blk = mem_q[rd_idx];

endmodule

// File: rtl/mab_ctrl.sv
// Record / drain sequencing, occupancy, overflow and done pulse.
module mab_ctrl
  import mab_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CORE_W = 5,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic              st_gen,
  input  logic              hit,
  input  logic              mc_valid,
  input  logic [CORE_W-1:0] mc_dest,
  input  logic              push_ready,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [CNT_W-1:0]  cnt,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              push_valid,
  output logic [CORE_W-1:0] push_dest,
  output logic              st_busy,
  output logic              drain_done,
  output logic              overflow
);

  mab_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  rd_q, rd_d;
  logic [CORE_W-1:0] dest_q, dest_d;
  logic              ovf_q, ovf_d;
  logic              done_q, done_d;

  logic recording, full, tag_store, drop, accept, finish;

  always_comb begin
    recording  = (state_q == MAB_RECORD);
    full       = (cnt_q == CNT_W'(DEPTH));
    tag_store  = recording && st_valid && st_gen;
    wr_en      = tag_store && !hit && !full;
    drop       = tag_store && !hit && full;
    push_valid = !recording && (rd_q != cnt_q);
    accept     = push_valid && push_ready;
    finish     = !recording &&
                 ((rd_q == cnt_q) || (accept && ((rd_q + CNT_W'(1)) == cnt_q)));
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rd_d    = rd_q;
    dest_d  = dest_q;
    ovf_d   = ovf_q;
    done_d  = 1'b0;
    if (recording) begin
      if (wr_en) cnt_d = cnt_q + CNT_W'(1);
      if (drop)  ovf_d = 1'b1;
      if (mc_valid) begin
        state_d = MAB_DRAIN;
        rd_d    = '0;
        dest_d  = mc_dest;
      end
    end else begin
      if (accept) rd_d = rd_q + CNT_W'(1);
      if (finish) begin
        state_d = MAB_RECORD;
        cnt_d   = '0;
        rd_d    = '0;
        ovf_d   = 1'b0;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MAB_RECORD;
      cnt_q   <= '0;
      rd_q    <= '0;
      dest_q  <= '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
      dest_q  <= dest_d;
      ovf_q   <= ovf_d;
      done_q  <= done_d;
    end
  end

  assign wr_idx     = cnt_q[IDX_W-1:0];
  assign cnt        = cnt_q;
  assign rd_idx     = rd_q[IDX_W-1:0];
  assign push_dest  = dest_q;
  assign st_busy    = !recording;
  assign drain_done = done_q;
  assign overflow   = ovf_q;

endmodule

// File: rtl/marshal_addr_buf.sv
module marshal_addr_buf #(
  parameter int PA_W   = 48,
  parameter int OFF_W  = 6,
  parameter int DEPTH  = 16,
  parameter int CORE_W = 5,
  localparam int BLK_W = PA_W - OFF_W,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [PA_W-1:0]   st_addr,
  input  logic              st_gen,
  output logic              st_busy,
  input  logic              mc_valid,
  input  logic [CORE_W-1:0] mc_dest,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [PA_W-1:0]   push_addr,
  output logic [CORE_W-1:0] push_dest,
  output logic              drain_done,
  output logic              overflow
);

  logic [BLK_W-1:0] st_blk;
  logic [BLK_W-1:0] rd_blk;
  logic             wr_en;
  logic             hit;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [CNT_W-1:0] cnt;

  assign st_blk = st_addr[PA_W-1:OFF_W];

  mab_entry_array #(
    .DEPTH (DEPTH),
    .BLK_W (BLK_W)
  ) u_array (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_blk (st_blk),
    .cnt    (cnt),
    .rd_idx (rd_idx),
    .rd_blk (rd_blk),
    .hit    (hit)
  );

  mab_ctrl #(
    .DEPTH  (DEPTH),
    .CORE_W (CORE_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_gen     (st_gen),
    .hit        (hit),
    .mc_valid   (mc_valid),
    .mc_dest    (mc_dest),
    .push_ready (push_ready),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .cnt        (cnt),
    .rd_idx     (rd_idx),
    .push_valid (push_valid),
    .push_dest  (push_dest),
    .st_busy    (st_busy),
    .drain_done (drain_done),
    .overflow   (overflow)
  );

  assign push_addr = {rd_blk, {OFF_W{1'b0}}};

endmodule

// File: rtl/mab_chk.sv
module mab_chk #(
  parameter int PA_W   = 48,
  parameter int CORE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_busy,
  input logic              push_valid,
  input logic              push_ready,
  input logic [PA_W-1:0]   push_addr,
  input logic [CORE_W-1:0] push_dest,
  input logic              drain_done,
  input logic              overflow
);

  // R8
  push_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> st_busy);

  // R6
  push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_addr) && $stable(push_dest)));

  // R5
  dest_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busy && push_valid) |=> (!st_busy || $stable(push_dest)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |=> !drain_done);

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> ($past(st_busy) && !st_busy));

  // R7
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overflow) |-> drain_done);

  // R3
  push_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> (push_addr[5:0] == 6'd0));

endmodule

bind marshal_addr_buf mab_chk #(
  .PA_W   (PA_W),
  .CORE_W (CORE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_busy    (st_busy),
  .push_valid (push_valid),
  .push_ready (push_ready),
  .push_addr  (push_addr),
  .push_dest  (push_dest),
  .drain_done (drain_done),
  .overflow   (overflow)
);

// File: tb/marshal_addr_buf_tb.sv
module marshal_addr_buf_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid, st_gen, st_busy;
  logic [47:0] st_addr;
  logic        mc_valid;
  logic [4:0]  mc_dest;
  logic        push_valid, push_ready;
  logic [47:0] push_addr;
  logic [4:0]  push_dest;
  logic        drain_done, overflow;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  logic [47:0] exp_a [32];
  int          exp_n;
  logic [47:0] got_a [32];
  int          got_n;

  always #10 clk = ~clk;

  marshal_addr_buf u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_addr    (st_addr),
    .st_gen     (st_gen),
    .st_busy    (st_busy),
    .mc_valid   (mc_valid),
    .mc_dest    (mc_dest),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .push_addr  (push_addr),
    .push_dest  (push_dest),
    .drain_done (drain_done),
    .overflow   (overflow)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_store(input logic [47:0] a, input logic g);
    st_valid = 1'b1; st_addr = a; st_gen = g;
    @(negedge clk);
    st_valid = 1'b0; st_gen = 1'b0;
  endtask

  task automatic do_marshal(input logic [4:0] d);
    mc_valid = 1'b1; mc_dest = d;
    @(negedge clk);
    mc_valid = 1'b0;
  endtask

  task automatic expect_add(input logic [47:0] a);
    exp_a[exp_n] = a;
    exp_n++;
  endtask

  // Called in the first drain cycle (negedge). Collects pushes until done.
  task automatic collect(input int stall, input logic [4:0] d, input string req);
    int last_acc = -1;
    int done_it = -1;
    logic hold = 1'b0;
    logic [47:0] hold_a = '0;
    got_n = 0;
    for (int it = 0; it < 200; it++) begin
      push_ready = (stall != 0) ? ((it % 3) != 0) : 1'b1;
      if (drain_done) begin
        done_it = it;
        break;
      end
      if (it == 0) chk({req, " R8 busy"}, 64'(st_busy), 64'd1);
      if (hold && push_valid) begin
        chk({req, " R6 hold"}, 64'(push_addr), 64'(hold_a));
        hold = 1'b0;
      end
      if (push_valid && !push_ready) begin
        hold = 1'b1; hold_a = push_addr;
      end
      if (push_valid && push_ready) begin
        chk({req, " R5 dest"}, 64'(push_dest), 64'(d));
        if (got_n < 32) got_a[got_n] = push_addr;
        got_n++;
        last_acc = it;
      end
      @(negedge clk);
    end
    push_ready = 1'b0;
    chk({req, " count"}, 64'(got_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk({req, " R5 order"}, 64'(got_a[i]), 64'(exp_a[i]));
    chk({req, " R9 done timing"}, 64'(done_it), (exp_n == 0) ? 64'd1 : 64'(last_acc + 1));
    @(negedge clk);
    chk({req, " R9 done one cycle"}, 64'(drain_done), 64'd0);
    chk({req, " R9 idle"}, 64'(st_busy), 64'd0);
    exp_n = 0;
  endtask

  task automatic t_reset;
    chk("R1 push_valid", 64'(push_valid), 64'd0);
    chk("R1 busy", 64'(st_busy), 64'd0);
    chk("R1 done", 64'(drain_done), 64'd0);
    chk("R1 overflow", 64'(overflow), 64'd0);
    do_marshal(5'd1);
    collect(0, 5'd1, "R1 empty");
  endtask

  task automatic t_order_align;
    exp_n = 0;
    do_store(48'h0000_1234_5678, 1'b1); expect_add(48'h0000_1234_5640);
    do_store(48'h0abc_0000_003f, 1'b1); expect_add(48'h0abc_0000_0000);
    do_store(48'hffff_ffff_ffc1, 1'b1); expect_add(48'hffff_ffff_ffc0);
    do_marshal(5'd3);
    collect(0, 5'd3, "R3 R5 order/align");
  endtask

  task automatic t_untagged_dup;
    exp_n = 0;
    do_store(48'h0000_0000_1000, 1'b0);
    do_store(48'h0000_0000_2008, 1'b1); expect_add(48'h0000_0000_2000);
    do_store(48'h0000_0000_3000, 1'b0);
    do_store(48'h0000_0000_2030, 1'b1);
    do_store(48'h0000_0000_4000, 1'b1); expect_add(48'h0000_0000_4000);
    do_store(48'h0000_0000_2000, 1'b1);
    do_marshal(5'd17);
    collect(0, 5'd17, "R2 R4 untagged/dup");
  endtask

  task automatic t_stall;
    exp_n = 0;
    for (int i = 0; i < 6; i++) begin
      do_store(48'h0000_5000_0000 + 48'(i) * 48'h1c0 + 48'd5, 1'b1);
      expect_add(48'h0000_5000_0000 + 48'(i) * 48'h1c0);
    end
    do_marshal(5'd30);
    collect(1, 5'd30, "R6 stall");
  endtask

  task automatic t_overflow;
    exp_n = 0;
    for (int i = 0; i < 16; i++) begin
      do_store(48'h0000_7000_0000 + 48'(i) * 48'h40, 1'b1);
      expect_add(48'h0000_7000_0000 + 48'(i) * 48'h40);
    end
    chk("R7 no overflow at 16", 64'(overflow), 64'd0);
    do_store(48'h0000_7000_0000, 1'b1);
    chk("R7 dup when full", 64'(overflow), 64'd0);
    do_store(48'h0000_7100_0000, 1'b1);
    chk("R7 overflow set", 64'(overflow), 64'd1);
    do_marshal(5'd8);
    chk("R7 overflow sticky in drain", 64'(overflow), 64'd1);
    collect(0, 5'd8, "R7 capacity");
    chk("R7 overflow cleared", 64'(overflow), 64'd0);
  endtask

  task automatic t_busy_ignore;
    exp_n = 0;
    do_store(48'h0000_0900_0040, 1'b1); expect_add(48'h0000_0900_0040);
    do_marshal(5'd4);
    push_ready = 1'b0;
    chk("R8 busy", 64'(st_busy), 64'd1);
    do_store(48'h0000_0a00_0000, 1'b1);
    do_marshal(5'd9);
    collect(0, 5'd4, "R8 during drain");
    do_marshal(5'd2);
    collect(0, 5'd2, "R8 R9 next generation empty");
  endtask

  task automatic t_same_cycle;
    exp_n = 0;
    do_store(48'h0000_0b00_0000, 1'b1); expect_add(48'h0000_0b00_0000);
    st_valid = 1'b1; st_addr = 48'h0000_0c00_0011; st_gen = 1'b1;
    mc_valid = 1'b1; mc_dest = 5'd12;
    expect_add(48'h0000_0c00_0000);
    @(negedge clk);
    st_valid = 1'b0; st_gen = 1'b0; mc_valid = 1'b0;
    collect(0, 5'd12, "R11 same cycle");
  endtask

  task automatic t_empty;
    exp_n = 0;
    do_marshal(5'd6);
    chk("R10 no push", 64'(push_valid), 64'd0);
    chk("R10 no early done", 64'(drain_done), 64'd0);
    @(negedge clk);
    chk("R10 done", 64'(drain_done), 64'd1);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_gen = 1'b0;
    mc_valid = 1'b0; mc_dest = '0; push_ready = 1'b0; exp_n = 0; got_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order_align();
    t_untagged_dup();
    t_stall();
    t_overflow();
    t_busy_ignore();
    t_same_cycle();
    t_empty();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule